// File: doc/BRIEF.md
# Dual-Band Two-Digit Logarithmic Multiply-Accumulate

This block is the arithmetic core of a symmetric filter pair. Each clock it takes one input sample and one coefficient, both in a two-digit double-base logarithmic form. A digit is a sign bit, a signed power-of-two exponent and a signed exponent of a fixed second base `BASE_D`. The block forms the four digit-by-digit partial products. Each one costs two small exponent additions, a lookup of the second-base power as a binary fixed-point value, and a barrel shift. The four results are merged by add/subtract stages whose operation is picked from the signs. The merged term goes into two binary accumulators.

The low-band and high-band filters share one coefficient magnitude stream. The high-band accumulator takes the same term, but negated on alternate coefficient indices. Which parity is negated depends on whether the filter pair has even or odd symmetry. A scheduler outside the block clears the accumulators with `acc_clr` at the start of a sample. It then asserts `mac_en` once per tap and reads both sums once the taps are done. The sums hold until the next clear.

Top module: `dlns_dual_band_mac`

## Requirements
- R1: A synchronous active-high `rst` sets both `low_sum` and `high_sum` to 0 at the next rising clock edge.
- R2: When `acc_clr` is high at a rising edge, both sums become 0 at that edge, even if `mac_en` is also high.
- R3: When `acc_clr` and `mac_en` are both low, both sums keep their values.
- R4: A nonzero digit pair with exponents (a_d, b_d) and (a_c, b_c) yields a magnitude M. First Q = round(BASE_D^(b_d+b_c) · 2^LUT_FRAC) is formed. M is Q shifted left by s = a_d+a_c+ACC_FRAC−LUT_FRAC, or shifted right (truncating) by −s when s is negative. The sums are two's complement with ACC_FRAC fraction bits, so 1.0 reads as 256 by default.
- R5: The term for one cycle is the signed sum of all four partial products: data digit 0 with coefficient digit 0, data 0 with coefficient 1, data 1 with coefficient 0, and data 1 with coefficient 1.
- R6: A sign bit of 1 means negative. The sign of each partial product is the XOR of its two digit signs.
- R7: A data digit whose second-base exponent is −16 (5'b10000), or a coefficient digit whose second-base exponent is −4 (3'b100), means zero. Every partial product that uses that digit contributes 0, and the other partial products are unchanged.
- R8: On a cycle with `mac_en` high and `acc_clr` low, `low_sum` increases by the term of R5 at that edge.
- R9: On the same cycle, `high_sum` increases by the same term when bit 0 of `cof_idx` differs from `sym_even`, and decreases by it when the two are equal. With even symmetry the odd taps are negated; with odd symmetry the even taps are negated.
- R10: Packed buses carry digit 0 in the low field and digit 1 in the next field up. Each field is the width of one exponent.
- R11: A partial product whose shift s is at or below −LUT_W, or at or above ACCW, contributes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_clr | input | 1 | Clear both accumulators |
| mac_en | input | 1 | Accumulate this cycle's product |
| dat_sgn | input | 2 | Data digit signs (1 = negative) |
| dat_aexp | input | 2*AW | Data power-of-two exponents, signed |
| dat_bexp | input | 2*DBW | Data second-base exponents, signed |
| cof_sgn | input | 2 | Coefficient digit signs |
| cof_aexp | input | 2*AW | Coefficient power-of-two exponents, signed |
| cof_bexp | input | 2*CBW | Coefficient second-base exponents, signed |
| cof_idx | input | IW | Coefficient tap index |
| sym_even | input | 1 | 1 for even filter symmetry, 0 for odd |
| low_sum | output | ACCW | Low-band accumulated sum |
| high_sum | output | ACCW | High-band accumulated sum |

## Verification
The bench builds the block with its defaults: 6-bit power-of-two exponents, a 5-bit data and 3-bit coefficient second-base exponent, a base of about 0.92, 12 lookup fraction bits and a 40-bit accumulator with 8 fraction bits. With these values a random stream reaches every lookup entry from −18 to 18 and both zero codes. It also drives shifts in both directions, including right shifts that wipe the whole lookup value. The exponent range is kept small enough that the exact reference sum never wraps.

// File: rtl/dlns_pkg.sv
package dlns_pkg;

  // Fixed-point power of the second base: round(base^e * 2^frac)
  function automatic int base_pow_q(real base, int e, int frac);
    real v;
    v = 1.0;
    if (e >= 0) begin
      for (int i = 0; i < e; i++) v = v * base;
    end else begin
      for (int i = 0; i < -e; i++) v = v / base;
    end
    for (int i = 0; i < frac; i++) v = v * 2.0;
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/dlns_pp_unit.sv
module dlns_pp_unit #(
  parameter int  AW       = 6,
  parameter int  DBW      = 5,
  parameter int  CBW      = 3,
  parameter int  LUT_W    = 16,
  parameter int  LUT_FRAC = 12,
  parameter int  ACCW     = 40,
  parameter int  ACC_FRAC = 8,
  parameter real BASE_D   = 0.92024380912663
) (
  input  logic            d_sgn,
  input  logic [AW-1:0]   d_a,
  input  logic [DBW-1:0]  d_b,
  input  logic            c_sgn,
  input  logic [AW-1:0]   c_a,
  input  logic [CBW-1:0]  c_b,
  output logic [ACCW-1:0] mag,
  output logic            p_sgn
);
  localparam int SBW    = DBW + 2;
  localparam int SHW    = AW + 2;
  localparam int B_MIN  = -(2 ** (DBW - 1)) + 1 - (2 ** (CBW - 1)) + 1;
  localparam int B_MAX  = (2 ** (DBW - 1)) - 1 + (2 ** (CBW - 1)) - 1;
  localparam int NLUT   = B_MAX - B_MIN + 1;
  localparam int IDXW   = $clog2(NLUT);
  localparam int SH_OFF = ACC_FRAC - LUT_FRAC;

  localparam logic [DBW-1:0] D_ZERO = {1'b1, {(DBW-1){1'b0}}};
  localparam logic [CBW-1:0] C_ZERO = {1'b1, {(CBW-1){1'b0}}};

  logic [LUT_W-1:0] lut [NLUT];

  for (genvar k = 0; k < NLUT; k++) begin : g_lut
    localparam int QV = dlns_pkg::base_pow_q(BASE_D, k + B_MIN, LUT_FRAC);
    assign lut[k] = LUT_W'(QV);
  end

  logic signed [SBW-1:0] b_sum;
  logic [SBW-1:0]        lut_idx;
  logic [LUT_W-1:0]      lut_val;
  logic signed [AW:0]    a_sum;
  logic signed [SHW-1:0] sh;
  logic [SHW-1:0]        nsh;
  logic [ACCW-1:0]       ext, shifted;
  logic                  any_zero;

  assign b_sum = $signed({{2{d_b[DBW-1]}}, d_b}) + $signed({{(SBW-CBW){c_b[CBW-1]}}, c_b});
  assign lut_idx = b_sum - SBW'(B_MIN);
  assign lut_val = (lut_idx < SBW'(NLUT)) ? lut[lut_idx[IDXW-1:0]] : '0;

  assign a_sum = $signed({d_a[AW-1], d_a}) + $signed({c_a[AW-1], c_a});
  assign sh    = $signed({a_sum[AW], a_sum}) + SHW'(SH_OFF);
  assign nsh   = -sh;
  assign ext   = ACCW'(lut_val);

  always_comb begin
    shifted = '0;
    if (!sh[SHW-1]) begin
      if (sh < SHW'(ACCW)) shifted = ext << sh;
    end else begin
      if (nsh < SHW'(LUT_W)) shifted = ext >> nsh;
    end
  end

  assign any_zero = (d_b == D_ZERO) || (c_b == C_ZERO);
  assign mag      = any_zero ? '0 : shifted;
  assign p_sgn    = d_sgn ^ c_sgn;
endmodule

// File: rtl/dlns_merge.sv
module dlns_merge #(
  parameter int ACCW = 40
) (
  input  logic [3:0][ACCW-1:0]   mag,
  input  logic [3:0]             sgn,
  output logic signed [ACCW-1:0] term,
  output logic                   ref_sgn
);
  logic signed [ACCW-1:0] pair_a, pair_b;

  // Three add/subtract stages; results are relative to channel 0's sign
  always_comb begin
    pair_a = (sgn[0] == sgn[1]) ? $signed(mag[0] + mag[1]) : $signed(mag[0] - mag[1]);
    pair_b = (sgn[2] == sgn[3]) ? $signed(mag[2] + mag[3]) : $signed(mag[2] - mag[3]);
    term   = (sgn[0] == sgn[2]) ? pair_a + pair_b : pair_a - pair_b;
  end

  assign ref_sgn = sgn[0];
endmodule

// File: rtl/dlns_band_acc.sv
module dlns_band_acc #(
  parameter int ACCW = 40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [ACCW-1:0] term,
  input  logic                   ref_sgn,
  input  logic                   flip,
  output logic signed [ACCW-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (en)     acc <= (ref_sgn ^ flip) ? acc - term : acc + term;
  end
endmodule

// File: rtl/dlns_dual_band_mac.sv
module dlns_dual_band_mac #(
  parameter int  AW       = 6,
  parameter int  DBW      = 5,
  parameter int  CBW      = 3,
  parameter int  IW       = 8,
  parameter int  LUT_W    = 16,
  parameter int  LUT_FRAC = 12,
  parameter int  ACCW     = 40,
  parameter int  ACC_FRAC = 8,
  parameter real BASE_D   = 0.92024380912663
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_clr,
  input  logic              mac_en,
  input  logic [1:0]        dat_sgn,
  input  logic [2*AW-1:0]   dat_aexp,
  input  logic [2*DBW-1:0]  dat_bexp,
  input  logic [1:0]        cof_sgn,
  input  logic [2*AW-1:0]   cof_aexp,
  input  logic [2*CBW-1:0]  cof_bexp,
  input  logic [IW-1:0]     cof_idx,
  input  logic              sym_even,
  output logic [ACCW-1:0]   low_sum,
  output logic [ACCW-1:0]   high_sum
);
  localparam int NCH   = 4;
  localparam int NBAND = 2;

  logic [NCH-1:0][ACCW-1:0]  ch_mag;
  logic [NCH-1:0]            ch_sgn;
  logic signed [ACCW-1:0]    term;
  logic                      ref_sgn;
  logic                      hi_flip;
  logic                      idx_unused;
  logic [NBAND-1:0][ACCW-1:0] sums;

  // Channel g pairs data digit g/2 with coefficient digit g%2
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int DI = g / 2;
    localparam int CI = g % 2;
    dlns_pp_unit #(
      .AW(AW), .DBW(DBW), .CBW(CBW), .LUT_W(LUT_W), .LUT_FRAC(LUT_FRAC),
      .ACCW(ACCW), .ACC_FRAC(ACC_FRAC), .BASE_D(BASE_D)
    ) u_pp (
      .d_sgn (dat_sgn[DI]),
      .d_a   (dat_aexp[DI*AW +: AW]),
      .d_b   (dat_bexp[DI*DBW +: DBW]),
      .c_sgn (cof_sgn[CI]),
      .c_a   (cof_aexp[CI*AW +: AW]),
      .c_b   (cof_bexp[CI*CBW +: CBW]),
      .mag   (ch_mag[g]),
      .p_sgn (ch_sgn[g])
    );
  end

  dlns_merge #(.ACCW(ACCW)) u_merge (
    .mag     (ch_mag),
    .sgn     (ch_sgn),
    .term    (term),
    .ref_sgn (ref_sgn)
  );

  // High band negated on odd taps for even symmetry, even taps for odd symmetry
  assign hi_flip    = (cof_idx[0] == sym_even);
  assign idx_unused = ^cof_idx[IW-1:1];

  for (genvar b = 0; b < NBAND; b++) begin : g_band
    dlns_band_acc #(.ACCW(ACCW)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .clr     (acc_clr),
      .en      (mac_en),
      .term    (term),
      .ref_sgn (ref_sgn),
      .flip    ((b == 1) ? hi_flip : 1'b0),
      .acc     (sums[b])
    );
  end

  assign low_sum  = sums[0];
  assign high_sum = sums[1];
endmodule

// File: rtl/dlns_dual_band_mac_chk.sv
module dlns_dual_band_mac_chk #(
  parameter int DBW  = 5,
  parameter int IW   = 8,
  parameter int ACCW = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_clr,
  input logic             mac_en,
  input logic [2*DBW-1:0] dat_bexp,
  input logic [IW-1:0]    cof_idx,
  input logic             sym_even,
  input logic [ACCW-1:0]  low_sum,
  input logic [ACCW-1:0]  high_sum
);
  localparam logic [DBW-1:0] ZB = {1'b1, {(DBW-1){1'b0}}};

  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    acc_clr |=> (low_sum == '0 && high_sum == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_clr && !mac_en) |=> ($stable(low_sum) && $stable(high_sum)));

  // R7
  zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !acc_clr && dat_bexp == {2{ZB}}) |=> ($stable(low_sum) && $stable(high_sum)));

  // R9
  hi_same_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !acc_clr && cof_idx[0] != sym_even)
      |=> ((low_sum - $past(low_sum)) == (high_sum - $past(high_sum))));

  // R9
  hi_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !acc_clr && cof_idx[0] == sym_even)
      |=> ((low_sum - $past(low_sum)) == ($past(high_sum) - high_sum)));
endmodule

bind dlns_dual_band_mac dlns_dual_band_mac_chk #(.DBW(DBW), .IW(IW), .ACCW(ACCW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_clr  (acc_clr),
  .mac_en   (mac_en),
  .dat_bexp (dat_bexp),
  .cof_idx  (cof_idx),
  .sym_even (sym_even),
  .low_sum  (low_sum),
  .high_sum (high_sum)
);

// File: tb/dlns_dual_band_mac_tb.sv
module dlns_dual_band_mac_tb;
  localparam int  CLK_P = 10;
  localparam real BASE  = 0.92024380912663;

  logic        clk = 1'b0;
  logic        rst, acc_clr, mac_en, sym_even;
  logic [1:0]  dat_sgn, cof_sgn;
  logic [11:0] dat_aexp, cof_aexp;
  logic [9:0]  dat_bexp;
  logic [5:0]  cof_bexp;
  logic [7:0]  cof_idx;
  logic [39:0] low_sum, high_sum;

  int total = 0, bad = 0;
  longint m_lo = 0, m_hi = 0;
  bit r_i, c_i, e_i, sy_i;
  bit ds[2], cs[2];
  int da[2], db[2], ca[2], cb[2], ix;

  always #(CLK_P/2) clk = ~clk;

  dlns_dual_band_mac u_dut (
    .clk(clk), .rst(rst), .acc_clr(acc_clr), .mac_en(mac_en),
    .dat_sgn(dat_sgn), .dat_aexp(dat_aexp), .dat_bexp(dat_bexp),
    .cof_sgn(cof_sgn), .cof_aexp(cof_aexp), .cof_bexp(cof_bexp),
    .cof_idx(cof_idx), .sym_even(sym_even),
    .low_sum(low_sum), .high_sum(high_sum)
  );

  function automatic longint pterm(bit s1, int a1, int b1, bit s2, int a2, int b2);
    longint v, m;
    int sh;
    if (b1 == -16 || b2 == -4) return 0;
    v  = longint'($rtoi($pow(BASE, real'(b1 + b2)) * 4096.0 + 0.5));
    sh = a1 + a2 + 8 - 12;
    if (sh >= 0) m = (sh < 40) ? (v << sh) : 0;
    else         m = (-sh < 16) ? (v >>> (-sh)) : 0;
    return (s1 ^ s2) ? -m : m;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(string req);
    longint p;
    rst = r_i; acc_clr = c_i; mac_en = e_i; sym_even = sy_i;
    cof_idx  = 8'(ix);
    dat_sgn  = {ds[1], ds[0]};
    cof_sgn  = {cs[1], cs[0]};
    dat_aexp = {6'(da[1]), 6'(da[0])};
    cof_aexp = {6'(ca[1]), 6'(ca[0])};
    dat_bexp = {5'(db[1]), 5'(db[0])};
    cof_bexp = {3'(cb[1]), 3'(cb[0])};
    @(posedge clk);
    if (r_i || c_i) begin
      m_lo = 0; m_hi = 0;
    end else if (e_i) begin
      p = 0;
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          p += pterm(ds[d], da[d], db[d], cs[c], ca[c], cb[c]);
      m_lo += p;
      m_hi += ((ix % 2) == int'(sy_i)) ? -p : p;
    end
    @(negedge clk);
    chk({req, " low"},  longint'($signed(low_sum)),  m_lo);
    chk({req, " high"}, longint'($signed(high_sum)), m_hi);
  endtask

  task automatic set_zero();
    ds = '{0, 0}; cs = '{0, 0};
    da = '{0, 0}; ca = '{0, 0};
    db = '{-16, -16}; cb = '{-4, -4};
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint hold;
    set_zero();
    r_i = 1; c_i = 0; e_i = 0; sy_i = 1; ix = 0;
    @(negedge clk);
    step("R1"); step("R1");
    r_i = 0;

    // R4: unit product 1.0 -> 256 in both bands (even tap, even symmetry)
    e_i = 1;
    db[0] = 0; cb[0] = 0;
    step("R4");
    chk("R4 unit", longint'($signed(low_sum)), 256);
    chk("R9 unit", longint'($signed(high_sum)), 256);

    // R4: exponents cancel in base D, power-of-two shift -2 -> +1024
    da[0] = 3; ca[0] = -1; db[0] = 1; cb[0] = -1;
    step("R4");
    chk("R4 shift", longint'($signed(low_sum)), 1280);

    // R6: negative data sign subtracts
    ds[0] = 1;
    step("R6");
    chk("R6 neg", longint'($signed(low_sum)), 256);
    ds[0] = 0; cs[0] = 1;
    step("R6");
    cs[0] = 0;

    // R3: idle cycles hold
    e_i = 0;
    hold = m_lo;
    da[0] = 5;
    step("R3"); step("R3"); step("R3");
    chk("R3 hold", longint'($signed(low_sum)), hold);

    // R7: zero codes
    e_i = 1;
    set_zero();
    da = '{4, 4}; ca = '{4, 4};
    step("R7");
    db[1] = 2; cb[0] = -1;
    step("R7");
    db[0] = -16; cb[1] = -4; db[1] = 2; cs[1] = 1; ds[0] = 1;
    step("R7");

    // R10: digit 1 only, distinct fields
    set_zero();
    ds[1] = 1; da[1] = 2; db[1] = -7; cs[1] = 0; ca[1] = -3; cb[1] = 3;
    step("R10");
    cb[0] = -2; ca[0] = 1;
    step("R10");

    // R9: all tap parity / symmetry combinations
    set_zero();
    db[0] = -3; da[0] = 1; cb[0] = 2; ca[0] = 0;
    for (int k = 0; k < 4; k++) begin
      ix = k; sy_i = (k >= 2);
      step("R9");
    end

    // R11: far right shift and far left shift wipe the term
    da = '{-20, -20}; ca = '{-20, -20}; db = '{0, 0}; cb = '{0, 0};
    step("R11");
    da = '{30, 30}; ca = '{20, 20};
    step("R11");

    // R2: clear wins over enable
    da = '{0, 0}; ca = '{0, 0};
    c_i = 1;
    step("R2");
    chk("R2 clr", longint'($signed(low_sum)), 0);
    c_i = 0;

    // R5 / R8: random stream
    for (int n = 0; n < 400; n++) begin
      for (int d = 0; d < 2; d++) begin
        ds[d] = 1'($urandom_range(1));
        cs[d] = 1'($urandom_range(1));
        da[d] = int'($urandom_range(16)) - 8;
        ca[d] = int'($urandom_range(16)) - 8;
        db[d] = int'($urandom_range(31)) - 16;
        cb[d] = int'($urandom_range(7)) - 4;
      end
      ix   = int'($urandom_range(255));
      sy_i = 1'($urandom_range(1));
      e_i  = ($urandom_range(7) != 0);
      c_i  = ($urandom_range(63) == 0);
      step(c_i ? "R2" : (e_i ? "R5" : "R3"));
    end
    c_i = 0; e_i = 0;

    // R1: reset mid-run
    r_i = 1;
    step("R1");
    chk("R1 mid", longint'($signed(high_sum)), 0);
    r_i = 0;
    step("R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule